// File: doc/BRIEF.md
# PCI configuration cycle router

The router sits beside the configuration address register of a host bridge. Each time software starts a configuration access, a one-cycle request strobe arrives with the latched 32-bit address. The router decodes the address and picks exactly one destination. It can claim the access for one of five local functions on bus 0. It can send the access down to one of two downstream ports whose bus-number window covers the target bus. Otherwise it forwards the access upstream as a Type 0 or Type 1 configuration packet, with a translated address.

The decision is kept in a small state machine. There is one state for each kind of outcome, and the routing outputs are decoded from that state.

States and transitions:

| State | Meaning |
|---|---|
| ST_RESET | Entered on reset. No decision has been made yet. |
| ST_LOCAL | The access is claimed by a local function. |
| ST_PORT | The access is steered to a downstream port. A registered index records which port. |
| ST_TYPE0 | The access is forwarded upstream as a Type 0 cycle. |
| ST_TYPE1 | The access is forwarded upstream as a Type 1 cycle. |
| ST_UNSUP | The access is unclaimed. The unsupported flag is raised so that read data can return all ones. |
| ST_IOPASS | The enable bit was clear, so the access is treated as ordinary I/O. |

From any state, a strobe moves the machine to the state chosen by the decode. Without a strobe the machine stays where it is.

Top module: `cfg_route_top`

## Requirements
- R1: Fields are taken from the address as follows: bus = bits 23:16, device = bits 15:11, function = bits 10:8. A locally claimed access presents its function number on `local_fn`.
- R2: If address bit 31 is 0, then after the strobe `io_pass` = 1, `route_sel` = 0, `unsup_req` = 0 and `fwd_addr` = 0.
- R3: A bus-0 access to device 0..4 whose bit in `dev_en` is 1 sets `route_sel` = 4'b0001. It also makes `local_sel` one-hot, with bit position equal to the device number, and sets `fwd_addr` = 0.
- R4: A bus-0 access is forwarded as Type 0 if it targets a device 0..4 whose bit in `dev_en` is 0, or any device 10..31. In that case `route_sel` = 4'b1000 and `fwd_addr` = {addr[31:2], 2'b00}.
- R5: A bus-0 access to device 5..9 sets `unsup_req` = 1, with `route_sel` = 0 and `fwd_addr` = 0.
- R6: A nonzero bus with sec ≤ bus ≤ sub for port p (inclusive) sets `route_sel` = 1 << (p+1). `route_sel` never has more than one bit set.
- R7: If both port windows contain the bus, port 0 wins.
- R8: A window whose subordinate number is below its secondary number matches no bus.
- R9: A nonzero bus that falls in no window is forwarded as Type 1. Then `route_sel` = 4'b1000 and `fwd_addr` = {addr[31:2], 2'b01}.
- R10: All outputs change on the clock edge that samples the strobe and on no other edge. Between strobes, changes on the address, `dev_en` or window inputs have no effect.
- R11: During reset, `route_sel`, `local_sel`, `local_fn`, `fwd_addr`, `unsup_req`, `io_pass` and `rt_valid` are all 0. `rt_valid` becomes 1 after the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 32 | Latched configuration address |
| req_vld | input | 1 | One-cycle request strobe |
| dev_en | input | 5 | Enable bits for local devices 0..4 |
| sec_bus | input | 16 | Secondary bus numbers; port p at bits 8p+7:8p |
| sub_bus | input | 16 | Subordinate bus numbers; port p at bits 8p+7:8p |
| route_sel | output | 4 | One-hot route: bit0 local, bit1 port 0, bit2 port 1, bit3 upstream |
| local_sel | output | 5 | One-hot select of the claimed local device |
| local_fn | output | 3 | Function number of a claimed local access |
| fwd_addr | output | 32 | Forwarded packet address, with the type in bits 1:0 |
| unsup_req | output | 1 | Access claimed by no target |
| io_pass | output | 1 | Enable bit clear; pass through as I/O |
| rt_valid | output | 1 | At least one decision has been made since reset |

## Verification
Two decisions can apply to the same access in the same cycle. A port window can cover bus 0 while a bus-0 access is made. Two port windows can both contain the bus of one access. The bench provokes the first case by programming a window whose secondary number is 0 and sending a bus-0 access to an enabled local device. It provokes the second with overlapping windows for both ports. A behavioural model, compared on every clock, judges both cases. It expects the bus-0 decision to ignore the windows and the lower port to win an overlap.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

    localparam int ADDR_W    = 32;
    localparam int BUS_W     = 8;
    localparam int DEV_W     = 5;
    localparam int FN_W      = 3;
    localparam int ENA_BIT   = 31;
    localparam int BUS_LSB   = 16;
    localparam int DEV_LSB   = 11;
    localparam int FN_LSB    = 8;
    localparam int TYPE_W    = 2;

    localparam logic [TYPE_W-1:0] KIND_T0 = 2'b00;
    localparam logic [TYPE_W-1:0] KIND_T1 = 2'b01;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_LOCAL,
        ST_PORT,
        ST_TYPE0,
        ST_TYPE1,
        ST_UNSUP,
        ST_IOPASS
    } route_st_e;

    typedef struct packed {
        logic              ena;
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FN_W-1:0]   fn;
    } cfg_fields_t;

    function automatic cfg_fields_t cfg_split(input logic [ADDR_W-1:0] a);
        cfg_fields_t f;
        f.ena = a[ENA_BIT];
        f.bus = a[BUS_LSB +: BUS_W];
        f.dev = a[DEV_LSB +: DEV_W];
        f.fn  = a[FN_LSB  +: FN_W];
        return f;
    endfunction

endpackage

// File: rtl/cfg_bus_window.sv
module cfg_bus_window #(
    parameter int BUS_W = 8
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [BUS_W-1:0] sec,
    input  logic [BUS_W-1:0] sub,
    output logic             hit
);
    logic above_lo;
    logic below_hi;

    always_comb begin
        above_lo = (bus >= sec);
        below_hi = (bus <= sub);
        hit      = (bus != '0) && above_lo && below_hi;
    end
endmodule

// File: rtl/cfg_port_prio.sv
module cfg_port_prio #(
    parameter int NPORTS = 2,
    parameter int IDX_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic [NPORTS-1:0] hits,
    output logic              any_hit,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        any_hit = |hits;
        idx     = '0;
        for (int i = NPORTS - 1; i >= 0; i--) begin
            if (hits[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/cfg_local_claim.sv
module cfg_local_claim #(
    parameter int NLOCAL = 5,
    parameter int FWD_LO = 10,
    parameter int DEV_W  = 5
) (
    input  logic              bus_zero,
    input  logic [DEV_W-1:0]  dev,
    input  logic [NLOCAL-1:0] dev_en,
    output logic              claim,
    output logic              pass0,
    output logic              unsup,
    output logic [NLOCAL-1:0] sel
);
    logic is_local;
    logic is_high;
    logic en_hit;

    always_comb begin
        is_local = 1'b0;
        en_hit   = 1'b0;
        sel      = '0;
        for (int i = 0; i < NLOCAL; i++) begin
            if (int'(dev) == i) begin
                is_local = 1'b1;
                en_hit   = dev_en[i];
                sel[i]   = bus_zero & dev_en[i];
            end
        end
        is_high = (int'(dev) >= FWD_LO);
        claim   = bus_zero &  is_local &  en_hit;
        pass0   = bus_zero & ((is_local & ~en_hit) | is_high);
        unsup   = bus_zero & ~is_local & ~is_high;
    end
endmodule

// File: rtl/cfg_route_top.sv
module cfg_route_top
    import cfg_route_pkg::*;
#(
    parameter int NPORTS = 2,
    parameter int NLOCAL = 5,
    parameter int FWD_LO = 10,
    localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int SEL_W = NPORTS + 2,
    localparam int UP_B  = NPORTS + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic                    req_vld,
    input  logic [NLOCAL-1:0]       dev_en,
    input  logic [NPORTS*BUS_W-1:0] sec_bus,
    input  logic [NPORTS*BUS_W-1:0] sub_bus,
    output logic [SEL_W-1:0]        route_sel,
    output logic [NLOCAL-1:0]       local_sel,
    output logic [FN_W-1:0]         local_fn,
    output logic [ADDR_W-1:0]       fwd_addr,
    output logic                    unsup_req,
    output logic                    io_pass,
    output logic                    rt_valid
);

    cfg_fields_t       fld;
    logic              bus_zero;
    logic [NPORTS-1:0] win_hit;
    logic              any_hit;
    logic [IDX_W-1:0]  hit_idx;
    logic              claim, pass0, unsup;
    logic [NLOCAL-1:0] claim_sel;
    route_st_e         dec_st, st_d, st_q;
    logic [IDX_W-1:0]  pidx_q;
    logic [NLOCAL-1:0] lsel_q;
    logic [FN_W-1:0]   fn_q;
    logic [ADDR_W-1:0] fwd_q;

    always_comb begin
        fld      = cfg_split(cfg_addr);
        bus_zero = (fld.bus == '0);
    end

    // one window comparator per downstream port
    for (genvar p = 0; p < NPORTS; p++) begin : g_win
        cfg_bus_window #(.BUS_W(BUS_W)) u_win (
            .bus (fld.bus),
            .sec (sec_bus[p*BUS_W +: BUS_W]),
            .sub (sub_bus[p*BUS_W +: BUS_W]),
            .hit (win_hit[p])
        );
    end

    cfg_port_prio #(.NPORTS(NPORTS), .IDX_W(IDX_W)) u_prio (
        .hits    (win_hit),
        .any_hit (any_hit),
        .idx     (hit_idx)
    );

    cfg_local_claim #(.NLOCAL(NLOCAL), .FWD_LO(FWD_LO), .DEV_W(DEV_W)) u_local (
        .bus_zero (bus_zero),
        .dev      (fld.dev),
        .dev_en   (dev_en),
        .claim    (claim),
        .pass0    (pass0),
        .unsup    (unsup),
        .sel      (claim_sel)
    );

    // outcome of the access presented this cycle
    always_comb begin
        if (!fld.ena)       dec_st = ST_IOPASS;
        else if (claim)     dec_st = ST_LOCAL;
        else if (pass0)     dec_st = ST_TYPE0;
        else if (unsup)     dec_st = ST_UNSUP;
        else if (any_hit)   dec_st = ST_PORT;
        else                dec_st = ST_TYPE1;
        st_d = req_vld ? dec_st : st_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    // payload registers, loaded only with a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pidx_q <= '0;
            lsel_q <= '0;
            fn_q   <= '0;
            fwd_q  <= '0;
        end else if (req_vld) begin
            pidx_q <= hit_idx;
            lsel_q <= '0;
            fn_q   <= '0;
            fwd_q  <= '0;
            unique case (dec_st)
                ST_LOCAL: begin
                    lsel_q <= claim_sel;
                    fn_q   <= fld.fn;
                end
                ST_TYPE0: fwd_q <= {cfg_addr[ADDR_W-1:TYPE_W], KIND_T0};
                ST_TYPE1: fwd_q <= {cfg_addr[ADDR_W-1:TYPE_W], KIND_T1};
                ST_RESET, ST_PORT, ST_UNSUP, ST_IOPASS: ;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        route_sel = '0;
        unique case (st_q)
            ST_LOCAL: route_sel[0] = 1'b1;
            ST_PORT: begin
                for (int p = 0; p < NPORTS; p++) begin
                    if (pidx_q == IDX_W'(p)) route_sel[p+1] = 1'b1;
                end
            end
            ST_TYPE0, ST_TYPE1: route_sel[UP_B] = 1'b1;
            ST_RESET, ST_UNSUP, ST_IOPASS: ;
        endcase
        local_sel = lsel_q;
        local_fn  = fn_q;
        fwd_addr  = fwd_q;
        unsup_req = (st_q == ST_UNSUP);
        io_pass   = (st_q == ST_IOPASS);
        rt_valid  = (st_q != ST_RESET);
    end

    // ---------------- assertions ----------------
    p_route_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(route_sel));

    p_io_noroute_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_vld) && !$past(cfg_addr[ENA_BIT]))
        |-> (io_pass && route_sel == '0 && fwd_addr == '0));

    p_local_bus0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_vld) && route_sel[0])
        |-> ($past(cfg_addr[BUS_LSB +: BUS_W]) == '0 && $countones(local_sel) == 1));

    p_unsup_noroute_r5: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_req |-> (route_sel == '0 && fwd_addr == '0));

    p_fwd_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        route_sel[UP_B] |-> (fwd_addr[1] == 1'b0 && fwd_addr[ENA_BIT]));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_vld) |-> ($stable(route_sel) && $stable(fwd_addr) && $stable(local_sel)));

endmodule

// File: tb/test_cfg_route_top.sv
module test_cfg_route_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_addr = '0;
    logic        req_vld = 1'b0;
    logic [4:0]  dev_en = 5'b11111;
    logic [7:0]  sec0 = 8'd2, sub0 = 8'd5, sec1 = 8'd8, sub1 = 8'd12;
    logic [3:0]  route_sel;
    logic [4:0]  local_sel;
    logic [2:0]  local_fn;
    logic [31:0] fwd_addr;
    logic        unsup_req, io_pass, rt_valid;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_tag = "R11";

    // expected state of the reference model
    logic [3:0]  e_sel = '0;
    logic [4:0]  e_lsel = '0;
    logic [2:0]  e_fn = '0;
    logic [31:0] e_fwd = '0;
    logic        e_uns = 0, e_io = 0, e_vld = 0;
    string       e_tag = "R11";

    always #4 clk = ~clk;

    cfg_route_top i_cfg_route_top (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .req_vld(req_vld),
        .dev_en(dev_en), .sec_bus({sec1, sec0}), .sub_bus({sub1, sub0}),
        .route_sel(route_sel), .local_sel(local_sel), .local_fn(local_fn),
        .fwd_addr(fwd_addr), .unsup_req(unsup_req), .io_pass(io_pass),
        .rt_valid(rt_valid)
    );

    // behavioural reference: updates only on a sampled strobe
    always @(posedge clk) begin
        int bus, dev;
        if (!rst_n) begin
            e_sel = '0; e_lsel = '0; e_fn = '0; e_fwd = '0;
            e_uns = 0; e_io = 0; e_vld = 0;
        end else if (req_vld) begin
            bus = int'(cfg_addr[23:16]);
            dev = int'(cfg_addr[15:11]);
            e_sel = '0; e_lsel = '0; e_fn = '0; e_fwd = '0;
            e_uns = 0; e_io = 0; e_vld = 1; e_tag = cur_tag;
            if (cfg_addr[31] == 1'b0) begin
                e_io = 1;
            end else if (bus == 0) begin
                if (dev < 5 && dev_en[dev]) begin
                    e_sel = 4'b0001; e_lsel = 5'(1 << dev); e_fn = cfg_addr[10:8];
                end else if (dev < 5 || dev > 9) begin
                    e_sel = 4'b1000; e_fwd = (cfg_addr >> 2) << 2;
                end else begin
                    e_uns = 1;
                end
            end else if (bus >= int'(sec0) && bus <= int'(sub0)) begin
                e_sel = 4'b0010;
            end else if (bus >= int'(sec1) && bus <= int'(sub1)) begin
                e_sel = 4'b0100;
            end else begin
                e_sel = 4'b1000; e_fwd = ((cfg_addr >> 2) << 2) | 32'd1;
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (route_sel !== e_sel || local_sel !== e_lsel || local_fn !== e_fn ||
                fwd_addr !== e_fwd || unsup_req !== e_uns || io_pass !== e_io ||
                rt_valid !== e_vld) begin
                n_bad++;
                $display("FAIL %s: got sel=%b lsel=%b fn=%0d fwd=%h uns=%b io=%b vld=%b exp sel=%b lsel=%b fn=%0d fwd=%h uns=%b io=%b vld=%b",
                    e_tag, route_sel, local_sel, local_fn, fwd_addr, unsup_req, io_pass, rt_valid,
                    e_sel, e_lsel, e_fn, e_fwd, e_uns, e_io, e_vld);
            end
        end
    end

    function automatic logic [31:0] mk(input int bus, input int dev, input int fn, input int rg);
        return {1'b1, 7'h15, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'b11};
    endfunction

    task automatic strobe(input logic [31:0] a, input string tag);
        @(negedge clk);
        cfg_addr = a; req_vld = 1'b1; cur_tag = tag;
        @(negedge clk);
        req_vld = 1'b0;
        cfg_addr = a ^ 32'h80FF_FF03;   // R10: scrambled address between strobes
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values
        n_cmp++;
        if (route_sel !== 0 || local_sel !== 0 || local_fn !== 0 || fwd_addr !== 0 ||
            unsup_req !== 0 || io_pass !== 0 || rt_valid !== 0) begin
            n_bad++;
            $display("FAIL R11: got sel=%b fwd=%h vld=%b exp all zero", route_sel, fwd_addr, rt_valid);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        strobe(mk(0, 1, 2, 4) & 32'h7FFF_FFFF, "R2");
        strobe(mk(3, 0, 0, 0) & 32'h7FFF_FFFF, "R2");
        for (int d = 0; d < 5; d++) strobe(mk(0, d, 7 - d, d * 3), "R3");
        strobe(mk(0, 2, 5, 9), "R1");
        dev_en = 5'b11011;
        strobe(mk(0, 2, 1, 1), "R4");
        strobe(mk(0, 3, 1, 1), "R3");
        dev_en = 5'b11111;
        strobe(mk(0, 10, 0, 0), "R4");
        strobe(mk(0, 31, 7, 63), "R4");
        strobe(mk(0, 5, 0, 0), "R5");
        strobe(mk(0, 9, 3, 0), "R5");
        strobe(mk(2, 0, 0, 0), "R6");
        strobe(mk(5, 1, 0, 0), "R6");
        strobe(mk(8, 0, 0, 0), "R6");
        strobe(mk(12, 4, 2, 0), "R6");
        strobe(mk(6, 0, 0, 0), "R9");
        strobe(mk(13, 0, 0, 0), "R9");
        strobe(mk(255, 31, 7, 63), "R9");
        // R7: overlapping windows
        sec1 = 8'd4; sub1 = 8'd9;
        strobe(mk(4, 0, 0, 0), "R7");
        strobe(mk(5, 0, 0, 0), "R7");
        strobe(mk(9, 0, 0, 0), "R7");
        // R8: inverted window on port 0
        sec0 = 8'd20; sub0 = 8'd15;
        sec1 = 8'd30; sub1 = 8'd40;
        strobe(mk(17, 0, 0, 0), "R8");
        strobe(mk(20, 0, 0, 0), "R8");
        strobe(mk(35, 0, 0, 0), "R6");
        // window covering bus 0 together with a bus-0 local access
        sec0 = 8'd0; sub0 = 8'd3;
        strobe(mk(0, 4, 6, 0), "R3");
        strobe(mk(1, 0, 0, 0), "R6");
        // R10: inputs move after the strobe; outputs must hold
        strobe(mk(0, 1, 3, 0), "R10");
        dev_en = 5'b00000; sec0 = 8'd0; sub0 = 8'd255;
        repeat (4) @(negedge clk);
        dev_en = 5'b11111;
        strobe(mk(0, 1, 3, 0), "R10");
        repeat (3) @(negedge clk);
        summary();
    end

endmodule